// File: doc/BRIEF.md
# Eight-bit ALU with condition flags

This block is the arithmetic and logic datapath of a small eight-bit processor core. It combines an accumulator register and a condition-flag register with combinational logic that joins the accumulator to a second operand. When `en_i` is high, the operation picked by `op_i` is evaluated in the same cycle. The accumulator and the flags take their new values at the next rising clock edge. The second operand comes from a temporary register outside the block and is presented on `opnd_i`.

The operations are add, subtract, increment, decrement, AND, OR, XOR, compare, complement, and one-bit left and right shifts. Five condition flags are kept: sign, zero, auxiliary carry (carry out of the low nibble), even parity and carry. Which flags an operation writes depends on the operation. Compare writes the flags exactly as subtract does and leaves the accumulator unchanged. There is no load operation. Software sets the accumulator to a value `v` by an AND with zero followed by an OR with `v`.

Top module: `alu8_flags`

## Requirements
- R1: While `rst_ni` is low, `acc_o` is 0x00 and `flags_o` is 0x02. Reset is asynchronous.
- R2: With `en_i` low, or with `op_i` equal to one of the unused codes 11 to 15, `acc_o` and `flags_o` do not change.
- R3: ADD (code 0) writes (A + B) mod 256 to the accumulator. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R4: Every operation that updates S, Z and P sets Z when its 8-bit result is zero and clears it otherwise. These operations are ADD, SUB, CMP, INC, DEC, AND, OR, XOR and NOT.
- R5: The same operations set S to bit 7 of the result.
- R6: The same operations set P when the result has an even number of ones and clear it when the number is odd.
- R7: SUB (code 1) writes (A - B) mod 256. CY is set when B > A as unsigned values. AC is set when A[3:0] >= B[3:0], which is the low-nibble carry of A + ~B + 1.
- R8: Flag layout in `flags_o`: S is bit 7, Z is bit 6, AC is bit 4, P is bit 2 and CY is bit 0. Bit 1 always reads 1, and bits 5 and 3 always read 0.
- R9: CMP (code 7) sets every flag as SUB would and leaves the accumulator unchanged.
- R10: INC (code 2) and DEC (code 3) write A + 1 and A - 1 modulo 256. For INC, AC is set when A[3:0] = 0xF. For DEC, AC is set when A[3:0] != 0. CY is unchanged.
- R11: AND (code 4), OR (code 5) and XOR (code 6) write the bitwise result and clear both CY and AC.
- R12: NOT (code 8) writes ~A and updates S, Z and P. AC and CY are unchanged.
- R13: SHL (code 9) writes {A[6:0],0} and SHR (code 10) writes {0,A[7:1]}. The bit shifted out goes to CY, and S, Z, AC and P are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Execute the operation on `op_i` at this edge |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Second operand from the temporary register |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Packed condition flags |

## Verification
The hardest behaviour to provoke is a flag being kept: INC, DEC, NOT and the shifts must leave a carry that is already 1. Every route that loads the accumulator clears the carry, so that state cannot be left over from a load. The bench therefore loads each accumulator value and then issues a compare against 0xFF, which borrows for every value below 0xFF and so sets CY without touching the accumulator. Only after that does it apply the unary operation. The same sequence with a compare against 0x00 covers a carry that is already clear.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int OP_W   = 4;
  localparam int FLAG_W = 8;
  localparam int S_BIT  = 7;
  localparam int Z_BIT  = 6;
  localparam int AC_BIT = 4;
  localparam int P_BIT  = 2;
  localparam int CY_BIT = 0;
  localparam logic [FLAG_W-1:0] FIXED_MASK = 8'b0010_1010;
  localparam logic [FLAG_W-1:0] FIXED_VAL  = 8'b0000_0010;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_INC = 4'd2, OP_DEC = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_CMP = 4'd7,
    OP_NOT = 4'd8, OP_SHL = 4'd9, OP_SHR = 4'd10
  } op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } cond_t;

  function automatic logic [FLAG_W-1:0] pack_cond(cond_t c);
    logic [FLAG_W-1:0] f;
    f         = FIXED_VAL;
    f[S_BIT]  = c.s;
    f[Z_BIT]  = c.z;
    f[AC_BIT] = c.ac;
    f[P_BIT]  = c.p;
    f[CY_BIT] = c.cy;
    return f;
  endfunction

  function automatic cond_t unpack_cond(logic [FLAG_W-1:0] f);
    cond_t c;
    c.s  = f[S_BIT];
    c.z  = f[Z_BIT];
    c.ac = f[AC_BIT];
    c.p  = f[P_BIT];
    c.cy = f[CY_BIT];
    return c;
  endfunction
endpackage

// File: rtl/alu8_adder.sv
`timescale 1ns/1ps
// Split adder: low part and high part, exposing carry out of the low part.
module alu8_adder #(
  parameter int DATA_W = 8,
  parameter int LOW_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_low_o,
  output logic              c_out_o
);
  localparam int HIGH_W = DATA_W - LOW_W;

  logic [LOW_W:0]  lo;
  logic [HIGH_W:0] hi;

  always_comb begin
    lo = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_i[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin_i};
    hi = {1'b0, a_i[DATA_W-1:LOW_W]} + {1'b0, b_i[DATA_W-1:LOW_W]}
       + {{HIGH_W{1'b0}}, lo[LOW_W]};
  end

  assign sum_o   = {hi[HIGH_W-1:0], lo[LOW_W-1:0]};
  assign c_low_o = lo[LOW_W];
  assign c_out_o = hi[HIGH_W];
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              shift_out_o
);
  always_comb begin
    res_o       = '0;
    shift_out_o = 1'b0;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_NOT: res_o = ~a_i;
      OP_SHL: begin
        res_o       = {a_i[DATA_W-2:0], 1'b0};
        shift_out_o = a_i[DATA_W-1];
      end
      OP_SHR: begin
        res_o       = {1'b0, a_i[DATA_W-1:1]};
        shift_out_o = a_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
`timescale 1ns/1ps
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOW_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [FLAG_W-1:0] flags_o
);
  op_e               op;
  logic [DATA_W-1:0] acc_q, add_b, sum, lg_res, res;
  logic [FLAG_W-1:0] flags_q;
  logic              add_cin, c_low, c_out, sh_out;
  logic              wr_acc, wr_flg, upd_szp;
  cond_t             cur, nxt;

  assign op  = op_e'(op_i);
  assign cur = unpack_cond(flags_q);

  // Adder operand: subtraction as A + ~B + 1, decrement as A + all-ones.
  always_comb begin
    add_b   = '0;
    add_cin = 1'b0;
    case (op)
      OP_ADD:         add_b = opnd_i;
      OP_SUB, OP_CMP: begin add_b = ~opnd_i; add_cin = 1'b1; end
      OP_INC:         add_cin = 1'b1;
      OP_DEC:         add_b = '1;
      default: ;
    endcase
  end

  alu8_adder #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_adder (
    .a_i    (acc_q),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (sum),
    .c_low_o(c_low),
    .c_out_o(c_out)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i       (op),
    .a_i        (acc_q),
    .b_i        (opnd_i),
    .res_o      (lg_res),
    .shift_out_o(sh_out)
  );

  always_comb begin
    nxt     = cur;
    res     = acc_q;
    wr_acc  = 1'b0;
    wr_flg  = 1'b0;
    upd_szp = 1'b0;
    case (op)
      OP_ADD: begin
        res = sum; wr_acc = 1'b1; wr_flg = 1'b1; upd_szp = 1'b1;
        nxt.ac = c_low; nxt.cy = c_out;
      end
      OP_SUB, OP_CMP: begin
        res = sum; wr_acc = (op == OP_SUB); wr_flg = 1'b1; upd_szp = 1'b1;
        nxt.ac = c_low; nxt.cy = ~c_out;  // borrow
      end
      OP_INC, OP_DEC: begin
        res = sum; wr_acc = 1'b1; wr_flg = 1'b1; upd_szp = 1'b1;
        nxt.ac = c_low;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res = lg_res; wr_acc = 1'b1; wr_flg = 1'b1; upd_szp = 1'b1;
        nxt.ac = 1'b0; nxt.cy = 1'b0;
      end
      OP_NOT: begin
        res = lg_res; wr_acc = 1'b1; wr_flg = 1'b1; upd_szp = 1'b1;
      end
      OP_SHL, OP_SHR: begin
        res = lg_res; wr_acc = 1'b1; wr_flg = 1'b1;
        nxt.cy = sh_out;
      end
      default: ;
    endcase
    if (upd_szp) begin
      nxt.s = res[DATA_W-1];
      nxt.z = ~|res;
      nxt.p = ~^res;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      flags_q <= FIXED_VAL;
    end else if (en_i) begin
      if (wr_acc) acc_q   <= res;
      if (wr_flg) flags_q <= pack_cond(nxt);
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/alu8_flags_chk.sv
`timescale 1ns/1ps
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [DATA_W-1:0] acc_o,
  input logic [FLAG_W-1:0] flags_o
);
  logic szp_op;
  assign szp_op = en_i && (op_i <= OP_NOT);

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || op_i > OP_SHR) |=> ($stable(acc_o) && $stable(flags_o)));

  a_r3_add_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_ADD) |=>
      ({flags_o[CY_BIT], acc_o} == {1'b0, $past(acc_o)} + {1'b0, $past(opnd_i)}));

  a_r4_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (szp_op && op_i != OP_CMP) |=> (flags_o[Z_BIT] == (acc_o == '0)));

  a_r5_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (szp_op && op_i != OP_CMP) |=> (flags_o[S_BIT] == acc_o[DATA_W-1]));

  a_r6_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (szp_op && op_i != OP_CMP) |=> (flags_o[P_BIT] == ~^acc_o));

  a_r7_sub_diff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_SUB) |=> (acc_o == DATA_W'($past(acc_o) - $past(opnd_i))));

  a_r8_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_o & FIXED_MASK) == FIXED_VAL));

  a_r9_cmp_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_CMP) |=>
      ($stable(acc_o) && flags_o[CY_BIT] == ($past(opnd_i) > $past(acc_o))));

  a_r10_incdec_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op_i == OP_INC || op_i == OP_DEC)) |=> $stable(flags_o[CY_BIT]));

  a_r11_logic_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=>
      (!flags_o[CY_BIT] && !flags_o[AC_BIT]));

  a_r13_shift_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op_i == OP_SHL || op_i == OP_SHR)) |=>
      (flags_o[FLAG_W-1:1] == $past(flags_o[FLAG_W-1:1])));
endmodule

bind alu8_flags alu8_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .op_i   (op_i),
  .opnd_i (opnd_i),
  .acc_o  (acc_o),
  .flags_o(flags_o)
);

// File: tb/alu8_flags_tb.sv
`timescale 1ns/1ps
module alu8_flags_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [3:0] op;
  logic [7:0] opnd;
  logic [7:0] acc, flags;

  logic [7:0] m_acc, m_flags;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu8_flags u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .opnd_i(opnd),
    .acc_o(acc), .flags_o(flags)
  );

  function automatic string tag_of(input logic e, input logic [3:0] o);
    if (!e) return "R2";
    case (o)
      4'd0: return "R3";
      4'd1: return "R7";
      4'd2, 4'd3: return "R10";
      4'd4, 4'd5, 4'd6: return "R11";
      4'd7: return "R9";
      4'd8: return "R12";
      4'd9, 4'd10: return "R13";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [7:0] b_of(input int k);
    case (k)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
      4: return 8'h7F;  5: return 8'h80;  6: return 8'hFF;  7: return 8'hFE;
      8: return 8'h11;  9: return 8'h22; 10: return 8'h5A; 11: return 8'hA5;
      12: return 8'h08; 13: return 8'hF0; 14: return 8'h33; default: return 8'hC8;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, acc, m_acc);
    chk("R5", flags[7], m_flags[7]);
    chk("R4", flags[6], m_flags[6]);
    chk("R6", flags[2], m_flags[2]);
    chk({tag, " AC"}, flags[4], m_flags[4]);
    chk({tag, " CY"}, flags[0], m_flags[0]);
    chk("R8", {flags[5], flags[3], flags[1]}, 3'b001);
  endtask

  task automatic model(input logic [3:0] o, input logic [7:0] b);
    int a, bb, r;
    logic s, z, ac, p, cy, szp, wr;
    a = m_acc; bb = b; r = a;
    s = m_flags[7]; z = m_flags[6]; ac = m_flags[4]; p = m_flags[2]; cy = m_flags[0];
    szp = 1'b1; wr = 1'b1;
    case (o)
      4'd0: begin r = (a + bb) % 256; cy = (a + bb) > 255; ac = (a % 16 + bb % 16) > 15; end
      4'd1, 4'd7: begin
        r = (a - bb + 256) % 256; cy = bb > a; ac = (a % 16) >= (bb % 16);
        wr = (o == 4'd1);
      end
      4'd2: begin r = (a + 1) % 256; ac = (a % 16) == 15; end
      4'd3: begin r = (a + 255) % 256; ac = (a % 16) != 0; end
      4'd4: begin r = a & bb; cy = 0; ac = 0; end
      4'd5: begin r = a | bb; cy = 0; ac = 0; end
      4'd6: begin r = a ^ bb; cy = 0; ac = 0; end
      4'd8: r = 255 - a;
      4'd9: begin r = (a * 2) % 256; cy = a >= 128; szp = 0; end
      4'd10: begin r = a / 2; cy = a % 2; szp = 0; end
      default: begin szp = 0; wr = 0; end
    endcase
    if (szp) begin
      s = r >= 128; z = r == 0; p = ($countones(8'(r)) % 2) == 0;
    end
    if (wr) m_acc = 8'(r);
    m_flags = {s, z, 1'b0, ac, 1'b0, p, 1'b1, cy};
  endtask

  // Drive at a falling edge, let the rising edge act, sample at the next falling edge.
  task automatic step(input logic [3:0] o, input logic [7:0] b, input logic e);
    en = e; op = o; opnd = b;
    @(negedge clk);
    en = 1'b0;
    if (e) model(o, b);
    check_all(tag_of(e, o));
  endtask

  task automatic load(input logic [7:0] v);
    step(4'd4, 8'h00, 1'b1);
    step(4'd5, v, 1'b1);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; op = 4'd0; opnd = 8'h00;
    m_acc = 8'h00; m_flags = 8'h02;
    repeat (3) @(negedge clk);
    chk("R1 acc", acc, 8'h00);
    chk("R1 flags", flags, 8'h02);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R7 R9 R11: two-operand sweep over every accumulator value
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 16; k++) begin
        load(8'(a)); step(4'd0, b_of(k), 1'b1);
        load(8'(a)); step(4'd1, b_of(k), 1'b1);
        load(8'(a)); step(4'd7, b_of(k), 1'b1);
        load(8'(a)); step(4'd4, b_of(k), 1'b1);
        load(8'(a)); step(4'd5, b_of(k), 1'b1);
        load(8'(a)); step(4'd6, b_of(k), 1'b1);
      end
    end

    // R10 R12 R13: unary operations with the carry preset to 1 (compare with 0xFF) and to 0
    for (int a = 0; a < 256; a++) begin
      for (int pre = 0; pre < 2; pre++) begin
        for (int o = 2; o <= 10; o++) begin
          if (o >= 4 && o <= 7) continue;
          load(8'(a));
          step(4'd7, (pre != 0) ? 8'hFF : 8'h00, 1'b1);
          step(4'(o), 8'h3C, 1'b1);
        end
      end
    end

    // R2: enable low for every code, then unused codes with enable high
    load(8'h5A);
    step(4'd7, 8'hFF, 1'b1);
    for (int o = 0; o < 16; o++) step(4'(o), 8'h33, 1'b0);
    for (int o = 11; o < 16; o++) step(4'(o), 8'h33, 1'b1);

    // R1: asynchronous reset in the middle of a run
    load(8'hC3);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async acc", acc, 8'h00);
    chk("R1 async flags", flags, 8'h02);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule